// File: doc/BRIEF.md
# Conditional Jump Address Unit

This block picks the address that a program counter loads on a jump instruction. It holds two values in its own registers: the count of the instruction after the jump, and the address the jump would go to. Each register loads on a rising clock edge only while its own active-low load strobe is low. The block compares the chosen condition against the compare flags that an arithmetic unit produces from its two operands. If the test passes, the stored target goes out. If it fails, the stored count goes out.

Three select lines choose which flags take part in the test: greater-than, less-than and equal-to. When no select line is active, the jump is unconditional, so one unit serves both jump kinds. When several select lines are active, the jump is taken if any selected flag is set. The address output is driven only while an active-low output enable is low. At all other times it is all zeros, so that it can be OR-merged onto a shared bus without tristate drivers. The output follows the select, flag and enable inputs combinationally, using the registered count and target. An asynchronous active-low reset clears both registers.

Top module: `jsel_unit`

## Requirements
- R1: While rst_n is low, both the count and target registers are 0, so with oe_n low the output is 0 whatever the selects are; the clear takes effect without a clock edge.
- R2: The count register takes cnt_in on a rising clock edge when cnt_ld_n is low, and keeps its value when cnt_ld_n is high.
- R3: The target register takes tgt_in on a rising clock edge when tgt_ld_n is low, and keeps its value when tgt_ld_n is high.
- R4: With oe_n low and cond_sel equal to 3'b000, the output is the stored target, whatever the flags are.
- R5: With exactly one cond_sel bit set (bit 0 greater, bit 1 less, bit 2 equal), the output is the stored target when the flag at the same bit position of cmp_flags is 1, and the stored count when it is 0.
- R6: With more than one cond_sel bit set, the output is the stored target if any selected flag is 1, and the stored count otherwise.
- R7: While oe_n is high, the output is all zeros.
- R8: A cmp_flags bit whose cond_sel bit is 0 has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers load on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_in | input | ADDR_W (5) | Count of the next instruction |
| cnt_ld_n | input | 1 | Active-low load strobe for the count register |
| tgt_in | input | ADDR_W (5) | Candidate jump target |
| tgt_ld_n | input | 1 | Active-low load strobe for the target register |
| cond_sel | input | 3 | Condition selects: bit 0 greater, bit 1 less, bit 2 equal |
| cmp_flags | input | 3 | Compare flags, in the same bit order as cond_sel |
| oe_n | input | 1 | Active-low output enable |
| nxt_addr | output | ADDR_W (5) | Next address, zero while disabled |

## Verification
The count and target are loaded with values that differ in every bit position. This makes it unambiguous which register reaches the output. A vector table then goes through the select and flag combinations: no select with both flag extremes, each single select with its own flag set and with only the other flags set, and pairs and triples of selects with a matching or non-matching flag. Together these cases separate an unconditional jump, a correct per-flag match, the OR over several selects, and flags that leak in although not selected. Directed steps show each load strobe holding its register while the other register loads, show the all-zero output while disabled, use all-ones and all-zero addresses, and apply an asynchronous reset between clock edges.

// File: rtl/jsel_pkg.sv
package jsel_pkg;
   // bit positions shared by cond_sel and cmp_flags
   localparam int unsigned COND_GT = 0;
   localparam int unsigned COND_LT = 1;
   localparam int unsigned COND_EQ = 2;
   localparam int unsigned COND_N  = 3;

   // source of the next address
   typedef enum logic [1:0] {
      SRC_CNT  = 2'd0,
      SRC_TGT  = 2'd1,
      SRC_NONE = 2'd2
   } jsel_src_e;
endpackage

// File: rtl/jsel_hold_reg.sv
module jsel_hold_reg #(
   parameter int unsigned W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("jsel_hold_reg: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (!ld_n)
         q <= d;
   end
endmodule

// File: rtl/jsel_cond_eval.sv
module jsel_cond_eval #(
   parameter int unsigned N              = 3,
   parameter bit          UNCOND_IF_NONE = 1'b1
) (
   input  logic [N-1:0] sel,
   input  logic [N-1:0] flags,
   output logic         take
);
   localparam int unsigned LAST = N - 1;

   logic [N-1:0] hit;
   logic [N-1:0] any_chain;

   generate
      if (N < 1) begin : g_bad_n
         $error("jsel_cond_eval: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_term
         assign hit[i] = sel[i] & flags[i];
         if (i == 0) begin : g_first
            assign any_chain[i] = hit[i];
         end else begin : g_next
            assign any_chain[i] = any_chain[i-1] | hit[i];
         end
      end
   endgenerate

   logic none_sel;
   assign none_sel = ~|sel;

   generate
      if (UNCOND_IF_NONE) begin : g_uncond
         assign take = none_sel | any_chain[LAST];
      end else begin : g_cond_only
         assign take = any_chain[LAST];
      end
   endgenerate
endmodule

// File: rtl/jsel_out_gate.sv
module jsel_out_gate
   import jsel_pkg::*;
#(
   parameter int unsigned W = 5
) (
   input  logic         take,
   input  logic         oe_n,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] tgt,
   output logic [W-1:0] addr
);
   jsel_src_e src;

   always_comb begin
      if (oe_n)
         src = SRC_NONE;
      else if (take)
         src = SRC_TGT;
      else
         src = SRC_CNT;
   end

   logic pick_cnt, pick_tgt;
   assign pick_cnt = (src == SRC_CNT);
   assign pick_tgt = (src == SRC_TGT);

   // AND-OR selection per bit, zero when neither source is picked
   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         assign addr[b] = (pick_cnt & cnt[b]) | (pick_tgt & tgt[b]);
      end
   endgenerate
endmodule

// File: rtl/jsel_unit.sv
module jsel_unit
   import jsel_pkg::*;
#(
   parameter int unsigned ADDR_W         = 5,
   parameter bit          UNCOND_IF_NONE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cnt_in,
   input  logic              cnt_ld_n,
   input  logic [ADDR_W-1:0] tgt_in,
   input  logic              tgt_ld_n,
   input  logic [COND_N-1:0] cond_sel,
   input  logic [COND_N-1:0] cmp_flags,
   input  logic              oe_n,
   output logic [ADDR_W-1:0] nxt_addr
);
   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("jsel_unit: ADDR_W must be within 1..32");
      end
   endgenerate

   logic [ADDR_W-1:0] cnt_q;
   logic [ADDR_W-1:0] tgt_q;
   logic              take;

   jsel_hold_reg #(.W(ADDR_W)) u_cnt_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .ld_n (cnt_ld_n),
      .d    (cnt_in),
      .q    (cnt_q)
   );

   jsel_hold_reg #(.W(ADDR_W)) u_tgt_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .ld_n (tgt_ld_n),
      .d    (tgt_in),
      .q    (tgt_q)
   );

   jsel_cond_eval #(.N(COND_N), .UNCOND_IF_NONE(UNCOND_IF_NONE)) u_eval (
      .sel  (cond_sel),
      .flags(cmp_flags),
      .take (take)
   );

   jsel_out_gate #(.W(ADDR_W)) u_gate (
      .take(take),
      .oe_n(oe_n),
      .cnt (cnt_q),
      .tgt (tgt_q),
      .addr(nxt_addr)
   );
endmodule

// File: rtl/jsel_unit_chk.sv
module jsel_unit_chk #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned CN     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cnt_in,
   input logic              cnt_ld_n,
   input logic [ADDR_W-1:0] tgt_in,
   input logic              tgt_ld_n,
   input logic [CN-1:0]     cond_sel,
   input logic [CN-1:0]     cmp_flags,
   input logic              oe_n,
   input logic [ADDR_W-1:0] nxt_addr,
   input logic [ADDR_W-1:0] cnt_q,
   input logic [ADDR_W-1:0] tgt_q
);
   // R2
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_ld_n |=> cnt_q == $past(cnt_in));
   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_ld_n |=> $stable(cnt_q));
   // R3
   tgt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_ld_n |=> tgt_q == $past(tgt_in));
   // R3
   tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_ld_n |=> $stable(tgt_q));
   // R4
   uncond_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n && cond_sel == '0) |-> nxt_addr == tgt_q);
   // R6
   no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n && cond_sel != '0 && (cond_sel & cmp_flags) == '0) |-> nxt_addr == cnt_q);
   // R5
   match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n && (cond_sel & cmp_flags) != '0) |-> nxt_addr == tgt_q);
   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> nxt_addr == '0);
endmodule

bind jsel_unit jsel_unit_chk #(.ADDR_W(ADDR_W), .CN(jsel_pkg::COND_N)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt_in   (cnt_in),
   .cnt_ld_n (cnt_ld_n),
   .tgt_in   (tgt_in),
   .tgt_ld_n (tgt_ld_n),
   .cond_sel (cond_sel),
   .cmp_flags(cmp_flags),
   .oe_n     (oe_n),
   .nxt_addr (nxt_addr),
   .cnt_q    (cnt_q),
   .tgt_q    (tgt_q)
);

// File: tb/sim_jsel_unit.sv
module sim_jsel_unit;
   localparam int unsigned AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] cnt_in = '0;
   logic          cnt_ld_n = 1'b1;
   logic [AW-1:0] tgt_in = '0;
   logic          tgt_ld_n = 1'b1;
   logic [2:0]    cond_sel = 3'b000;
   logic [2:0]    cmp_flags = 3'b000;
   logic          oe_n = 1'b0;
   logic [AW-1:0] nxt_addr;

   int n_run = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   jsel_unit #(.ADDR_W(AW)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_in   (cnt_in),
      .cnt_ld_n (cnt_ld_n),
      .tgt_in   (tgt_in),
      .tgt_ld_n (tgt_ld_n),
      .cond_sel (cond_sel),
      .cmp_flags(cmp_flags),
      .oe_n     (oe_n),
      .nxt_addr (nxt_addr)
   );

   // {sel[2:0], flags[2:0], oe_n, exp[1:0]}; exp 0=count 1=target 2=zero
   localparam int NV = 14;
   localparam logic [8:0] VEC [NV] = '{
      {3'b000, 3'b000, 1'b0, 2'd1},
      {3'b000, 3'b111, 1'b0, 2'd1},
      {3'b001, 3'b001, 1'b0, 2'd1},
      {3'b001, 3'b110, 1'b0, 2'd0},
      {3'b010, 3'b010, 1'b0, 2'd1},
      {3'b010, 3'b101, 1'b0, 2'd0},
      {3'b100, 3'b100, 1'b0, 2'd1},
      {3'b100, 3'b011, 1'b0, 2'd0},
      {3'b011, 3'b010, 1'b0, 2'd1},
      {3'b011, 3'b100, 1'b0, 2'd0},
      {3'b111, 3'b100, 1'b0, 2'd1},
      {3'b101, 3'b010, 1'b0, 2'd0},
      {3'b001, 3'b001, 1'b1, 2'd2},
      {3'b000, 3'b000, 1'b1, 2'd2}
   };

   task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: nxt_addr=%0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_bad++;
         n_run++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] cval, tval, ev;
      string tag;
      // R1: reset state
      cnt_in = 5'd7; tgt_in = 5'd11; cnt_ld_n = 1'b0; tgt_ld_n = 1'b0;
      step();
      chk("R1", nxt_addr, 5'd0);
      cond_sel = 3'b001;
      #1 chk("R1", nxt_addr, 5'd0);
      rst_n = 1'b1;
      cnt_ld_n = 1'b1; tgt_ld_n = 1'b1; cond_sel = 3'b000;
      step();

      // R2: load count only; target must stay 0 (R3 hold)
      cnt_in = 5'd9; cnt_ld_n = 1'b0; tgt_in = 5'd22;
      step();
      cnt_ld_n = 1'b1;
      cond_sel = 3'b001; cmp_flags = 3'b000;
      #1 chk("R2", nxt_addr, 5'd9);
      cond_sel = 3'b000;
      #1 chk("R3", nxt_addr, 5'd0);

      // R3: load target only; count must hold (R2)
      @(negedge clk);
      cnt_in = 5'd3; tgt_in = 5'd22; tgt_ld_n = 1'b0;
      step();
      tgt_ld_n = 1'b1;
      cond_sel = 3'b000;
      #1 chk("R3", nxt_addr, 5'd22);
      cond_sel = 3'b010; cmp_flags = 3'b000;
      #1 chk("R2", nxt_addr, 5'd9);

      // table walk: count 9 (01001), target 22 (10110)
      cval = 5'd9; tval = 5'd22;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         cond_sel  = VEC[i][8:6];
         cmp_flags = VEC[i][5:3];
         oe_n      = VEC[i][2];
         ev = (VEC[i][1:0] == 2'd1) ? tval : (VEC[i][1:0] == 2'd0) ? cval : 5'd0;
         if (VEC[i][2])                         tag = "R7";
         else if (VEC[i][8:6] == 3'b000)        tag = "R4";
         else if ($countones(VEC[i][8:6]) > 1) tag = "R6";
         else if ((VEC[i][5:3] & ~VEC[i][8:6]) != 3'b000) tag = "R8";
         else                                   tag = "R5";
         #1 chk(tag, nxt_addr, ev);
      end

      // extremes: target 31, count 0
      @(negedge clk);
      oe_n = 1'b0;
      cnt_in = 5'd0; tgt_in = 5'd31; cnt_ld_n = 1'b0; tgt_ld_n = 1'b0;
      step();
      cnt_ld_n = 1'b1; tgt_ld_n = 1'b1;
      cond_sel = 3'b100; cmp_flags = 3'b100;
      #1 chk("R5", nxt_addr, 5'd31);
      cmp_flags = 3'b011;
      #1 chk("R8", nxt_addr, 5'd0);
      cond_sel = 3'b000;
      oe_n = 1'b1;
      #1 chk("R7", nxt_addr, 5'd0);
      oe_n = 1'b0;
      #1 chk("R4", nxt_addr, 5'd31);

      // R1: asynchronous clear between edges
      @(posedge clk);
      #1 rst_n = 1'b0;
      #0.5 chk("R1", nxt_addr, 5'd0);
      step();
      rst_n = 1'b1;
      step();
      chk("R1", nxt_addr, 5'd0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule